// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Length

This block turns bytes from a 16-entry queue into asynchronous serial frames on a single output line. All frame timing runs off a one-cycle enable at sixteen times the bit rate (`tick16`). A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop phase. The stop phase length is chosen by a 4-bit code in sixteenths of a bit. Word length, parity and stop code are captured when a character is taken from the queue, so they can be changed safely once the line is idle.

A request-to-send output is set and cleared by the host. An optional auto-negate mode supports half-duplex turnaround. The host loads the last bytes, then drops `tx_en`. The queued characters still go out, and one bit time after the line has fully drained, request-to-send drops by itself. A clear-to-send gate can hold back the start of new characters. Two status outputs show that there is room in the queue and that the transmitter is completely empty.

Top module: `uart_tx_frac`

## Requirements
- R1: The line idles high. A frame is a 16-tick low start bit followed by the data bits, least significant first, each lasting 16 ticks. `char_len` gives the number of data bits: 00=5, 01=6, 10=7, 11=8. Unused upper bits of the written byte are not sent.
- R2: With `par_en`=1, one 16-tick parity bit follows the data bits. With `par_odd`=0 it makes the count of ones over data and parity even; with `par_odd`=1 it makes that count odd.
- R3: The stop phase is held high for `stop_code`+9 ticks when the code is 0..7, and for `stop_code`+17 ticks when the code is 8..15. A queued character that is allowed to start begins right after the stop phase, with no idle gap.
- R4: For 5-bit characters, codes 0..7 add 8 ticks to the stop phase, giving 17..24 ticks. Codes 8..15 are unchanged.
- R5: The queue holds 16 bytes. `tx_rdy` is `tx_en` AND not full. A write (`wr_valid`) is accepted only while `tx_rdy` is high; any other write is dropped and never sent.
- R6: `tx_emt` is high exactly when the queue is empty and no character is in progress, including its stop phase.
- R7: With `cts_gate_en`=1, a character starts only while `cts` is high. A character already started always completes even if `cts` falls. With `cts_gate_en`=0, `cts` has no effect.
- R8: `rts_set` drives `rts` high from the next cycle and `rts_clr` drives it low. If both are high in the same cycle, clear wins. Reset leaves `rts` low.
- R9: With `auto_rts`=1, `tx_en`=0 and `rts` high, `rts` drops exactly 16 ticks after `tx_emt` rises. With `auto_rts`=0, `rts` is never dropped automatically.
- R10: Dropping `tx_en` does not stop characters already queued. While `tx_en`=1, `rts` is never dropped automatically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable at 16x the bit rate |
| tx_en | input | 1 | Transmitter enable (gates writes and auto-negate) |
| wr_valid | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Byte to queue |
| char_len | input | 2 | Data bits: 00=5 … 11=8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| stop_code | input | 4 | Stop length code in sixteenths |
| cts_gate_en | input | 1 | Enable clear-to-send gating |
| cts | input | 1 | Clear-to-send, active high |
| rts_set | input | 1 | Drive request-to-send high |
| rts_clr | input | 1 | Drive request-to-send low |
| auto_rts | input | 1 | Auto-negate request-to-send after drain |
| txd | output | 1 | Serial line |
| rts | output | 1 | Request-to-send, active high |
| tx_rdy | output | 1 | Queue can accept a byte |
| tx_emt | output | 1 | Queue and shifter empty |

## Verification
A line monitor rebuilds each frame tick by tick and compares it with queued expectations. It checks every data bit, the parity bit and the measured length of the high stop run. Bytes such as A5, 3C, FF and 00 tell a bit-order or shift fault apart from a stuck bit. A top bit of 1 sent in a 7-bit or 6-bit frame shows whether unused bits leak out. Batches are sent back to back at codes 0, 3, 7, 8 and 15, in both 5-bit and wider frames, so the stop measurement separates the two code ranges, the 5-bit offset, and any idle gap between frames. Holding clear-to-send low while the queue fills, and then dropping it mid-frame, separates the start gate from the completion of a frame already in progress. The turnaround sequence measures the exact delay between drain and the fall of request-to-send.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the fractional-stop serial transmitter.
// Assumes a 16x bit-rate enable: every bit is 16 ticks long.
package uart_tx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int CNT_W         = 6;   // holds stop lengths up to 32 ticks

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    // Stop length in ticks from the 4-bit code; short codes get +8 for 5-bit chars.
    function automatic logic [CNT_W-1:0] stop_ticks(input logic [3:0] code,
                                                    input logic       five_bit);
        logic [CNT_W-1:0] t;
        t = code[3] ? (CNT_W'(code) + CNT_W'(17)) : (CNT_W'(code) + CNT_W'(9));
        if (five_bit && !code[3]) begin
            t = t + CNT_W'(8);
        end
        return t;
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
// Byte queue feeding the transmitter.
// Assumes push is already gated by !full by the caller; pop only when !empty.
module uart_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign rdata = mem[rd_ptr];

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r5_full_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/uart_tx_shifter.sv
// Frame sequencer: start, 5..8 data bits LSB first, optional parity, stop in ticks.
// Assumes tick is a one-cycle enable at 16x bit rate; the format is latched per character.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              avail,
    input  logic              cts_ok,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [3:0]        stop_code,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int LEN_W = $clog2(DATA_W);
    localparam int NB_W  = LEN_W + 1;
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TICKS_PER_BIT - 1);

    tx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [NB_W-1:0]   nbits, nb_load;
    logic [LEN_W-1:0]  bit_idx;
    logic              par_q, par_load, pen_q;
    logic [CNT_W-1:0]  stop_q;
    logic [DATA_W-1:0] masked;
    logic              start_ok, stop_end;

    assign nb_load  = NB_W'(5) + NB_W'(char_len);
    assign start_ok = avail && cts_ok;
    assign stop_end = (state == TX_STOP) && (cnt == stop_q - 1'b1);
    assign pop      = tick && start_ok && ((state == TX_IDLE) || stop_end);
    assign busy     = (state != TX_IDLE);

    // Parity of the bits that will actually be sent.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = rdata[i] && (i < int'(nb_load));
        end
        par_load = (^masked) ^ par_odd;
    end

    // Frame state machine, advancing once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            txd     <= 1'b1;
            cnt     <= '0;
            shreg   <= '0;
            nbits   <= '0;
            bit_idx <= '0;
            par_q   <= 1'b0;
            pen_q   <= 1'b0;
            stop_q  <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
            if (pop) begin
                state   <= TX_START;
                txd     <= 1'b0;
                cnt     <= '0;
                shreg   <= rdata;
                nbits   <= nb_load;
                par_q   <= par_load;
                pen_q   <= par_en;
                stop_q  <= stop_ticks(stop_code, char_len == 2'b00);
            end else begin
                case (state)
                    TX_IDLE: begin
                        txd <= 1'b1;
                        cnt <= '0;
                    end
                    TX_START: if (cnt == BIT_LAST) begin
                        state   <= TX_DATA;
                        txd     <= shreg[0];
                        cnt     <= '0;
                        bit_idx <= '0;
                    end
                    TX_DATA: if (cnt == BIT_LAST) begin
                        cnt <= '0;
                        if (NB_W'(bit_idx) == nbits - 1'b1) begin
                            state <= pen_q ? TX_PAR : TX_STOP;
                            txd   <= pen_q ? par_q : 1'b1;
                        end else begin
                            shreg   <= shreg >> 1;
                            txd     <= shreg[1];
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    TX_PAR: if (cnt == BIT_LAST) begin
                        state <= TX_STOP;
                        txd   <= 1'b1;
                        cnt   <= '0;
                    end
                    TX_STOP: if (stop_end) begin
                        state <= TX_IDLE;
                        txd   <= 1'b1;
                        cnt   <= '0;
                    end
                    default: begin
                        state <= TX_IDLE;
                        txd   <= 1'b1;
                    end
                endcase
            end
        end
    end

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE || state == TX_STOP) |-> txd);
    a_r1_start_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START) |-> !txd);

endmodule

// File: rtl/uart_tx_rts.sv
// Request-to-send register with optional automatic negation after drain.
// Assumes drained reflects an empty queue and idle shifter; the delay is 16 ticks.
module uart_tx_rts
    import uart_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rts_set,
    input  logic rts_clr,
    input  logic auto_en,
    input  logic tx_en,
    input  logic drained,
    output logic rts
);
    localparam int DW = $clog2(TICKS_PER_BIT);

    logic [DW-1:0] dly;
    logic          armed;

    assign armed = auto_en && !tx_en && drained && rts;

    // Host set/clear plus the auto-negate at the end of the one-bit delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts <= 1'b0;
        end else if (rts_clr) begin
            rts <= 1'b0;
        end else if (rts_set) begin
            rts <= 1'b1;
        end else if (armed && tick && (dly == DW'(TICKS_PER_BIT - 1))) begin
            rts <= 1'b0;
        end
    end

    // One-bit delay counter, restarted whenever the arming condition breaks.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            dly <= '0;
        end else if (tick) begin
            dly <= dly + 1'b1;
        end
    end

    a_r8_set_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_set && !rts_clr) |=> rts);
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rts_clr |=> !rts);

endmodule

// File: rtl/uart_tx_frac.sv
// Top of the serial transmitter: queue, frame sequencer and request-to-send control.
// Assumes tick16 is a single-cycle enable; config is changed only while tx_emt is high.
module uart_tx_frac
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [3:0]        stop_code,
    input  logic              cts_gate_en,
    input  logic              cts,
    input  logic              rts_set,
    input  logic              rts_clr,
    input  logic              auto_rts,
    output logic              txd,
    output logic              rts,
    output logic              tx_rdy,
    output logic              tx_emt
);
    logic              push, pop, empty, full, busy, cts_ok;
    logic [DATA_W-1:0] rdata;

    assign tx_rdy = tx_en && !full;
    assign push   = wr_valid && tx_rdy;
    assign cts_ok = !cts_gate_en || cts;
    assign tx_emt = empty && !busy;

    uart_tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(wr_data), .pop(pop),
        .rdata(rdata), .empty(empty), .full(full)
    );

    uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .avail(!empty), .cts_ok(cts_ok),
        .rdata(rdata), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .stop_code(stop_code), .pop(pop), .txd(txd), .busy(busy)
    );

    uart_tx_rts u_rts (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rts_set(rts_set), .rts_clr(rts_clr),
        .auto_en(auto_rts), .tx_en(tx_en), .drained(tx_emt), .rts(rts)
    );

    a_r6_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_emt |-> txd);
    a_r7_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cts_gate_en) |-> cts);
    a_r9_no_drop_before_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (rts && !tx_emt && !rts_clr) |=> rts);
    a_r10_no_auto_drop_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rts && tx_en && !rts_clr) |=> rts);

endmodule

// File: tb/sim_uart_tx_frac.sv
// Scoreboard bench: the driver queues expected frames, a line monitor rebuilds and compares them.
module sim_uart_tx_frac;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pe;
        bit         po;
        int         st;
    } frame_t;

    logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
    logic       tx_en = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = 2'b11;
    logic       par_en = 1'b0, par_odd = 1'b0;
    logic [3:0] stop_code = 4'd7;
    logic       cts_gate_en = 1'b0, cts = 1'b0;
    logic       rts_set = 1'b0, rts_clr = 1'b0, auto_rts = 1'b0;
    logic       txd, rts, tx_rdy, tx_emt;

    int     n_chk = 0, n_fail = 0;
    frame_t exp_q[$];
    bit     done = 1'b0;

    uart_tx_frac u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .stop_code(stop_code), .cts_gate_en(cts_gate_en), .cts(cts), .rts_set(rts_set),
        .rts_clr(rts_clr), .auto_rts(auto_rts), .txd(txd), .rts(rts), .tx_rdy(tx_rdy),
        .tx_emt(tx_emt)
    );

    always #5 clk = ~clk;

    // 16x enable: high every second cycle.
    always @(posedge clk) tick16 <= ~tick16;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One line sample per tick, taken just before the edge that acts on it.
    task automatic next_sample(output logic v);
        do @(negedge clk); while (!tick16);
        v = txd;
    endtask

    task automatic write_byte(input logic [7:0] d, input bit expect_sent);
        frame_t f;
        int     code;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        if (expect_sent) begin
            code = int'(stop_code);
            f.nb = 5 + int'(char_len);
            f.d  = d & 8'((1 << f.nb) - 1);
            f.pe = par_en;
            f.po = par_odd;
            f.st = (code < 8) ? code + 9 : code + 17;
            if (f.nb == 5 && code < 8) f.st += 8;
            exp_q.push_back(f);
        end
    endtask

    task automatic set_fmt(input logic [1:0] len, input bit pe, input bit po,
                           input logic [3:0] code);
        @(negedge clk);
        char_len = len; par_en = pe; par_odd = po; stop_code = code;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(tx_emt && exp_q.size() == 0));
        repeat (120) @(negedge clk);
    endtask

    // Line monitor: decodes every frame and compares with the scoreboard.
    initial begin
        logic   v;
        bit     pending = 1'b0;
        frame_t e;
        int     tot, hc;
        logic [7:0] got;
        logic   gpar;
        forever begin
            if (!pending) begin
                do next_sample(v); while (!(rst_n && v === 1'b0));
            end
            pending = 1'b0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected frame", 1, 0);
                e.nb = 8; e.pe = 0; e.po = 0; e.st = 0; e.d = '0;
            end else begin
                e = exp_q.pop_front();
            end
            tot = 1 + e.nb + int'(e.pe);
            got = '0; gpar = 1'b0;
            for (int n = 1; n < tot * 16; n++) begin
                next_sample(v);
                if (n == 8) check(v == 1'b0, "R1 start bit", int'(v), 0);
                if (n % 16 == 8 && n >= 16) begin
                    if (n / 16 <= e.nb) got[n / 16 - 1] = v;
                    else gpar = v;
                end
            end
            check(got == e.d, "R1 data bits", int'(got), int'(e.d));
            if (e.pe) begin
                check(gpar == ((^e.d) ^ e.po), "R2 parity bit", int'(gpar),
                      int'((^e.d) ^ e.po));
            end
            hc = 0;
            while (hc < 40) begin
                next_sample(v);
                if (v === 1'b0) begin
                    pending = 1'b1;
                    break;
                end
                hc++;
            end
            if (pending) begin
                if (e.nb == 5 && e.st >= 17 && e.st <= 24)
                    check(hc == e.st, "R4 stop length 5-bit", hc, e.st);
                else
                    check(hc == e.st, "R3 stop length", hc, e.st);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        check(txd == 1'b1, "R1 idle line after reset", int'(txd), 1);
        check(tx_emt == 1'b1, "R6 empty after reset", int'(tx_emt), 1);
        check(rts == 1'b0, "R8 rts low after reset", int'(rts), 0);
        check(tx_rdy == 1'b0, "R5 not ready while disabled", int'(tx_rdy), 0);
        write_byte(8'h55, 1'b0);   // dropped: tx_en low
        repeat (100) @(negedge clk);
        check(tx_emt == 1'b1 && txd == 1'b1, "R5 write while disabled dropped", int'(tx_emt), 1);
        tx_en = 1'b1;
        @(negedge clk);
        check(tx_rdy == 1'b1, "R5 ready when enabled", int'(tx_rdy), 1);

        // R1/R3: 8 bits, no parity, code 7 -> 16 ticks.
        set_fmt(2'b11, 0, 0, 4'd7);
        write_byte(8'hA5, 1); write_byte(8'h3C, 1); write_byte(8'hFF, 1); write_byte(8'h00, 1);
        @(negedge clk);
        check(tx_emt == 1'b0, "R6 busy while sending", int'(tx_emt), 0);
        wait_idle();
        // R2: 7 bits even parity, code 0 -> 9 ticks; top bit must not be sent.
        set_fmt(2'b10, 1, 0, 4'd0);
        write_byte(8'h5A, 1); write_byte(8'h7F, 1); write_byte(8'h81, 1);
        wait_idle();
        // R2: 6 bits odd parity, code 15 -> 32 ticks.
        set_fmt(2'b01, 1, 1, 4'd15);
        write_byte(8'hC3, 1); write_byte(8'h2A, 1); write_byte(8'h00, 1);
        wait_idle();
        // R4: 5 bits code 3 -> 20 ticks; code 8 -> 25 ticks (no offset).
        set_fmt(2'b00, 0, 0, 4'd3);
        write_byte(8'h15, 1); write_byte(8'hEA, 1);
        wait_idle();
        set_fmt(2'b00, 1, 0, 4'd8);
        write_byte(8'h0F, 1); write_byte(8'h10, 1);
        wait_idle();
        // R3: 8 bits code 8 -> 25 ticks.
        set_fmt(2'b11, 0, 0, 4'd8);
        write_byte(8'h96, 1); write_byte(8'h69, 1);
        wait_idle();

        // R7/R5: gate closed, fill the queue, then overflow.
        set_fmt(2'b11, 0, 0, 4'd7);
        cts_gate_en = 1'b1; cts = 1'b0;
        for (int i = 0; i < 16; i++) write_byte(8'(i * 17 + 3), 1);
        @(negedge clk);
        check(tx_rdy == 1'b0, "R5 not ready when full", int'(tx_rdy), 0);
        write_byte(8'hEE, 0);      // must be dropped
        repeat (200) @(negedge clk);
        check(txd == 1'b1 && tx_emt == 1'b0, "R7 no start while cts low", int'(txd), 1);
        check(exp_q.size() == 16, "R7 nothing sent while cts low", exp_q.size(), 16);
        cts = 1'b1;
        do @(negedge clk); while (exp_q.size() != 15);
        repeat (50) @(negedge clk);
        cts = 1'b0;                // in-progress frame must finish
        repeat (1000) @(negedge clk);
        check(exp_q.size() == 15, "R7 only current frame completes", exp_q.size(), 15);
        check(txd == 1'b1 && tx_rdy == 1'b1, "R7 line idle after cts drop", int'(txd), 1);
        cts = 1'b1;
        wait_idle();
        cts_gate_en = 1'b0; cts = 1'b0;   // gate off: cts ignored
        write_byte(8'h42, 1);
        wait_idle();
        check(exp_q.size() == 0, "R7 cts ignored when gate off", exp_q.size(), 0);

        // R8: host set / clear / both.
        @(negedge clk); rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        check(rts == 1'b1, "R8 set", int'(rts), 1);
        rts_clr = 1'b1; @(negedge clk); rts_clr = 1'b0;
        check(rts == 1'b0, "R8 clear", int'(rts), 0);
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b1; rts_clr = 1'b1;
        @(negedge clk); rts_set = 1'b0; rts_clr = 1'b0;
        check(rts == 1'b0, "R8 clear wins", int'(rts), 0);

        // R9: auto off, disabled and drained: rts stays.
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        tx_en = 1'b0;
        repeat (200) @(negedge clk);
        check(rts == 1'b1, "R9 no auto drop when auto off", int'(rts), 1);
        // R10: auto on but enabled: rts stays.
        tx_en = 1'b1; auto_rts = 1'b1;
        repeat (200) @(negedge clk);
        check(rts == 1'b1, "R10 no auto drop while enabled", int'(rts), 1);
        // R9/R10: turnaround sequence.
        write_byte(8'hB7, 1); write_byte(8'h4E, 1);
        @(negedge clk); tx_en = 1'b0;
        do @(negedge clk); while (!tx_emt);
        check(exp_q.size() == 0, "R10 queued frames sent after disable", exp_q.size(), 0);
        check(rts == 1'b1, "R9 rts held until drain", int'(rts), 1);
        cnt = 0;
        forever begin
            do @(negedge clk); while (!tick16);
            if (rts !== 1'b1) break;
            cnt++;
            if (cnt > 100) break;
        end
        check(cnt == 16, "R9 rts drops one bit after drain", cnt, 16);
        repeat (100) @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule